// File: doc/BRIEF.md
# Segment Register Load Validator

This block decides whether a descriptor that has just been fetched may be placed in one of four segment registers: code, stack, or one of the two data registers. The caller supplies the target register, a flag that marks a null selector, and the attribute bits of the descriptor: present, segment/system, executable, conforming/expand-down, readable/writable, and the 4-bit system type. The block returns exactly one verdict. The verdict is either the load is allowed, a general-protection fault with a zero error code, or a not-present fault. When the descriptor is a system descriptor, the block also reports what kind of system descriptor it was.

Requests enter through a valid/ready input stream and results leave through a valid/ready output stream. The block holds a single result register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The result is shown on the next cycle and stays there, unchanged, until the consumer takes it with `out_ready`. `in_ready` is high whenever the result register is empty or is being drained in the same cycle, so back-to-back requests run at full rate when the consumer never stalls. Privilege comparison, gate following and task switching are left to other logic.

Top module: `segld_check`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. A request accepted on one rising edge produces `out_valid`=1 from the next edge. `in_ready` = !`out_valid` | `out_ready`.
- R2: While `out_valid`=1 and `out_ready`=0, `out_valid` and every result field hold their values.
- R3: Whenever `out_valid`=1, exactly one of `out_ok`, `out_gp`, `out_np` is 1.
- R4: With `in_null`=1, targets DS (2) and ES (3) give ok and targets CS (0) and SS (1) give a general-protection fault, whatever the other attribute bits are. The kind is 0 and the wide flag is 0.
- R5: A non-null descriptor with `in_sbit`=0 gives a general-protection fault for every target.
- R6: For target CS, `in_exec`=0 gives a general-protection fault. `in_exec`=1 passes the type check whatever `in_rw` and `in_ce` are.
- R7: For target SS, only `in_exec`=0 with `in_rw`=1 passes the type check. An executable descriptor or a read-only data descriptor gives a general-protection fault.
- R8: For targets DS and ES, `in_exec`=1 with `in_rw`=0 (execute-only code) gives a general-protection fault. Readable code and all data descriptors pass the type check.
- R9: A non-null descriptor that passes its type check gives a not-present fault when `in_present`=0, and ok otherwise. A descriptor that fails its type check gives a general-protection fault even when `in_present`=0.
- R10: For a non-null descriptor with `in_sbit`=0, `out_kind` decodes `in_systype` as follows: 1,9 give 1 (available task state); 3,B give 2 (busy task state); 2 gives 3 (local table); 4,C give 4 (call gate); 5 gives 5 (task gate); 6,E give 6 (interrupt gate); 7,F give 7 (trap gate); 0,8,A,D give 8 (reserved). In every other case `out_kind` is 0.
- R11: `out_wide` is 1 exactly for system types 9, B, C, E and F on a non-null descriptor with `in_sbit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request is offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_target | input | 2 | Target register: 0 CS, 1 SS, 2 DS, 3 ES |
| in_null | input | 1 | Selector is null |
| in_present | input | 1 | Descriptor present bit |
| in_sbit | input | 1 | 1 = code/data segment, 0 = system descriptor |
| in_exec | input | 1 | Executable bit |
| in_ce | input | 1 | Conforming / expand-down bit |
| in_rw | input | 1 | Readable (code) / writable (data) bit |
| in_systype | input | 4 | System descriptor type code |
| out_valid | output | 1 | Result is shown |
| out_ready | input | 1 | Consumer takes the result |
| out_ok | output | 1 | Load allowed |
| out_gp | output | 1 | General-protection fault, error code 0 |
| out_np | output | 1 | Not-present fault |
| out_kind | output | 4 | Kind of rejected system descriptor (R10 encoding) |
| out_wide | output | 1 | System descriptor is the 32-bit form |

## Verification
The assertions assume that the request fields are meaningful only on an edge where `in_valid` and `in_ready` are both high. They also assume that `in_valid` is low through reset, so that the first `$past` sample after reset cannot describe a request. The bench drives its fields only at the falling edge and drops `in_valid` straight after each transfer. It applies a stall pattern on `out_ready` so that the hold rules are tested on real results, including runs of consecutive stalls.

// File: rtl/segld_pkg.sv
package segld_pkg;
  localparam int TARGET_W = 2;
  localparam int SYSTYPE_W = 4;
  localparam int KIND_W = 4;

  typedef enum logic [TARGET_W-1:0] {
    SR_CS = 2'd0,
    SR_SS = 2'd1,
    SR_DS = 2'd2,
    SR_ES = 2'd3
  } seg_reg_e;

  typedef enum logic [KIND_W-1:0] {
    SK_NONE      = 4'd0,
    SK_TSS_AVAIL = 4'd1,
    SK_TSS_BUSY  = 4'd2,
    SK_LOCAL_TBL = 4'd3,
    SK_CALL_GATE = 4'd4,
    SK_TASK_GATE = 4'd5,
    SK_INT_GATE  = 4'd6,
    SK_TRAP_GATE = 4'd7,
    SK_RESERVED  = 4'd8
  } sys_kind_e;

  typedef struct packed {
    logic                 null_sel;
    logic                 present;
    logic                 sbit;
    logic                 exec;
    logic                 ce;
    logic                 rw;
    logic [SYSTYPE_W-1:0] systype;
  } attr_t;

  typedef struct packed {
    logic      ok;
    logic      gp;
    logic      np;
    sys_kind_e kind;
    logic      wide;
  } verdict_t;
endpackage

// File: rtl/segld_kind_decode.sv
module segld_kind_decode
  import segld_pkg::*;
(
  input  logic [SYSTYPE_W-1:0] code,
  output sys_kind_e            kind,
  output logic                 wide
);
  always_comb begin
    wide = 1'b0;
    unique case (code)
      4'h1: kind = SK_TSS_AVAIL;
      4'h9: begin kind = SK_TSS_AVAIL; wide = 1'b1; end
      4'h3: kind = SK_TSS_BUSY;
      4'hB: begin kind = SK_TSS_BUSY; wide = 1'b1; end
      4'h2: kind = SK_LOCAL_TBL;
      4'h4: kind = SK_CALL_GATE;
      4'hC: begin kind = SK_CALL_GATE; wide = 1'b1; end
      4'h5: kind = SK_TASK_GATE;
      4'h6: kind = SK_INT_GATE;
      4'hE: begin kind = SK_INT_GATE; wide = 1'b1; end
      4'h7: kind = SK_TRAP_GATE;
      4'hF: begin kind = SK_TRAP_GATE; wide = 1'b1; end
      default: kind = SK_RESERVED;
    endcase
  end
endmodule

// File: rtl/segld_rules.sv
module segld_rules
  import segld_pkg::*;
(
  input  seg_reg_e target,
  input  attr_t    attr,
  output verdict_t verdict
);
  sys_kind_e dec_kind;
  logic      dec_wide;
  logic      type_bad;
  logic      unused_ce;

  segld_kind_decode u_dec (
    .code (attr.systype),
    .kind (dec_kind),
    .wide (dec_wide)
  );

  // conforming / expand-down never changes the verdict
  assign unused_ce = attr.ce;

  always_comb begin
    unique case (target)
      SR_CS:   type_bad = !attr.exec;
      SR_SS:   type_bad = attr.exec || !attr.rw;
      default: type_bad = attr.exec && !attr.rw;
    endcase
  end

  always_comb begin
    verdict = '{ok: 1'b0, gp: 1'b0, np: 1'b0, kind: SK_NONE, wide: 1'b0};
    if (attr.null_sel) begin
      if (target == SR_DS || target == SR_ES) verdict.ok = 1'b1;
      else                                    verdict.gp = 1'b1;
    end else if (!attr.sbit) begin
      verdict.gp   = 1'b1;
      verdict.kind = dec_kind;
      verdict.wide = dec_wide;
    end else if (type_bad) begin
      verdict.gp = 1'b1;
    end else if (!attr.present) begin
      verdict.np = 1'b1;
    end else begin
      verdict.ok = 1'b1;
    end
  end
endmodule

// File: rtl/segld_check.sv
module segld_check
  import segld_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [TARGET_W-1:0]  in_target,
  input  logic                 in_null,
  input  logic                 in_present,
  input  logic                 in_sbit,
  input  logic                 in_exec,
  input  logic                 in_ce,
  input  logic                 in_rw,
  input  logic [SYSTYPE_W-1:0] in_systype,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_ok,
  output logic                 out_gp,
  output logic                 out_np,
  output logic [KIND_W-1:0]    out_kind,
  output logic                 out_wide
);
  attr_t    attr;
  verdict_t next_v;
  verdict_t res_q;
  logic     valid_q;
  logic     take;

  assign attr = '{null_sel: in_null, present: in_present, sbit: in_sbit,
                  exec: in_exec, ce: in_ce, rw: in_rw, systype: in_systype};

  segld_rules u_rules (
    .target  (seg_reg_e'(in_target)),
    .attr    (attr),
    .verdict (next_v)
  );

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        res_q   <= next_v;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_ok    = res_q.ok;
  assign out_gp    = res_q.gp;
  assign out_np    = res_q.np;
  assign out_kind  = res_q.kind;
  assign out_wide  = res_q.wide;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready) |-> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(out_valid && !out_ready) |->
      out_valid && $stable({out_ok, out_gp, out_np, out_kind, out_wide}));

  p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_ok, out_gp, out_np}) == 1);

  p_null_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && in_null) |-> (out_ok == $past(in_target[1])));

  p_system_gp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && !in_null && !in_sbit) |-> out_gp);

  p_ss_writable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && !in_null && in_target == 2'd1) && out_ok
      |-> $past(!in_exec && in_rw));

  p_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && !in_null && !in_present) |-> !out_ok);
endmodule

// File: tb/sim_segld_check.sv
`timescale 1ns/1ps
module sim_segld_check;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_target = '0;
  logic       in_null = 1'b0, in_present = 1'b0, in_sbit = 1'b0;
  logic       in_exec = 1'b0, in_ce = 1'b0, in_rw = 1'b0;
  logic [3:0] in_systype = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_ok, out_gp, out_np, out_wide;
  logic [3:0] out_kind;

  int errors = 0;
  int checks = 0;
  int sent = 0;
  int got = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  segld_check u0 (.*);

  task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference from the requirements: {ok,gp,np,kind[3:0],wide}
  function automatic logic [7:0] model(input logic [1:0] t, input logic nul, p, s, x, rw,
                                       input logic [3:0] ty, output string tag);
    logic ok = 0, gp = 0, np = 0, wide = 0, bad;
    logic [3:0] k = 0;
    if (nul) begin
      tag = "R4";
      if (t >= 2) ok = 1; else gp = 1;
    end else if (!s) begin
      tag = "R5/R10/R11";
      gp = 1;
      case (ty)
        4'h1, 4'h9: k = 1;
        4'h3, 4'hB: k = 2;
        4'h2: k = 3;
        4'h4, 4'hC: k = 4;
        4'h5: k = 5;
        4'h6, 4'hE: k = 6;
        4'h7, 4'hF: k = 7;
        default: k = 8;
      endcase
      wide = (ty == 4'h9 || ty == 4'hB || ty == 4'hC || ty == 4'hE || ty == 4'hF);
    end else begin
      if (t == 0)      begin bad = !x;         tag = "R6"; end
      else if (t == 1) begin bad = x || !rw;   tag = "R7"; end
      else             begin bad = x && !rw;   tag = "R8"; end
      if (!p) tag = {tag, "/R9"};
      if (bad) gp = 1; else if (!p) np = 1; else ok = 1;
    end
    return {ok, gp, np, k, wide};
  endfunction

  task automatic send(input logic [1:0] t, input logic nul, p, s, x, ce, rw, input logic [3:0] ty);
    string tg;
    @(negedge clk);
    in_target = t; in_null = nul; in_present = p; in_sbit = s;
    in_exec = x; in_ce = ce; in_rw = rw; in_systype = ty;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(model(t, nul, p, s, x, rw, ty, tg));
    tag_q.push_back(tg);
    sent++;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // stall pattern on the consumer side, changed just after each rising edge
  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      #1;
      n++;
      out_ready = bp_en ? ((n % 5) != 1 && (n % 7) != 3 && (n % 7) != 4) : 1'b1;
    end
  end

  // monitor / scoreboard
  logic       prev_stall = 1'b0;
  logic [7:0] prev_word = '0;
  initial begin
    forever begin
      logic [7:0] w;
      @(negedge clk);
      if (rst_n) begin
        w = {out_ok, out_gp, out_np, out_kind, out_wide};
        if (prev_stall) check(out_valid && w == prev_word, "R2", {out_valid, w}, {1'b1, prev_word});
        if (out_valid) check($countones({out_ok, out_gp, out_np}) == 1, "R3", w, 8'h0);
        if (out_valid && out_ready) begin
          got++;
          if (exp_q.size() == 0) check(1'b0, "R1", w, 8'hxx);
          else begin
            logic [7:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(w == e, tg, w, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_word  = w;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", {out_valid, in_ready}, 2'b01);

    // R1 latency: one request, result on the following cycle
    @(negedge clk);
    in_target = 2'd2; in_null = 1'b0; in_present = 1'b1; in_sbit = 1'b1;
    in_exec = 1'b0; in_ce = 1'b0; in_rw = 1'b1; in_systype = 4'h0;
    in_valid = 1'b1;
    begin
      string tg;
      exp_q.push_back(model(2'd2, 0, 1, 1, 0, 1, 4'h0, tg));
      tag_q.push_back(tg);
    end
    sent++;
    @(posedge clk);
    #1 in_valid = 1'b0;
    check(out_valid && out_ok, "R1", {out_valid, out_ok}, 2'b11);

    // directed corner cases
    send(2'd0, 1, 1, 1, 1, 0, 1, 4'h0);  // R4 null CS -> gp
    send(2'd3, 1, 0, 0, 0, 0, 0, 4'h5);  // R4 null ES -> ok
    send(2'd1, 0, 0, 1, 1, 0, 1, 4'h0);  // R9 wrong type not present -> gp
    send(2'd1, 0, 0, 1, 0, 0, 1, 4'h0);  // R9 ok type not present -> np
    send(2'd0, 0, 1, 1, 1, 1, 0, 4'h0);  // R6 execute-only conforming CS -> ok
    send(2'd2, 0, 1, 1, 1, 0, 0, 4'h0);  // R8 execute-only into DS -> gp

    // sweep with back-pressure
    bp_en = 1'b1;
    for (int t = 0; t < 4; t++)
      for (int b = 0; b < 64; b++)
        send(t[1:0], b[5], b[4], b[3], b[2], b[1], b[0], b[3:0] ^ t[3:0]);
    for (int t = 0; t < 4; t++)
      for (int ty = 0; ty < 16; ty++)
        send(t[1:0], 1'b0, ty[0], 1'b0, ty[1], ty[2], ty[3], ty[3:0]);  // R10 R11

    bp_en = 1'b0;
    repeat (10) @(negedge clk);
    check(got == sent && exp_q.size() == 0, "R1", got, sent);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule